// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel with Nested Transfer Loops

This block is one DMA channel that copies data between two memory-mapped regions on behalf of a peripheral. A transfer descriptor held in local registers defines the move. It holds the source and destination addresses and their signed per-beat offsets. It also holds the source and destination beat widths, the byte count moved per request (the inner loop) and the iteration count of the outer loop. Two signed adjustments are applied to the addresses once the outer loop finishes.

Each peripheral request moves one inner loop. Data passes through an 8-byte staging register, so a narrow side and a wide side can be paired. After every inner loop the current iteration count steps down by one. When the count runs out it reloads from the starting value and the channel reports completion. Software arms the channel through a write-only register port and reads results from dedicated status outputs. A misaligned or inconsistent descriptor is caught before any data moves, and it blocks the channel until software clears the error.

Top module: `dmaeng_channel`

## Requirements
- R1: After reset, `done_o`, `irq_o`, `err_flags_o`, `err_o`, `busy_o`, `mem_req` and `cur_iter_o` are all zero.
- R2: Each accepted request reads and writes exactly NBYTES bytes (register 4), and `cur_iter_o` falls by one per inner loop. Writing register 7 loads both the starting and the current iteration count.
- R3: When the inner loop that brings the count to zero finishes, the current count reloads from the starting count and status bit 0 (`done_o`) is set. `irq_o` (status bit 1) is also set if control bit 1 is set.
- R4: When control bit 2 is set, `irq_o` is set at the inner-loop boundary where the current count becomes the starting count divided by two, rounded down.
- R5: The source address advances by the signed 16-bit offset in register 2 bits [15:0] after each read. The destination address advances by the offset in bits [31:16] after each write. After the last inner loop of an outer loop, the signed values in register 5 and register 6 are added to the source and destination addresses.
- R6: Requests are accepted only while control bit 0 (register 8) is set. Requests arriving while it is clear are dropped. Clearing and setting the bit again keeps the current count and both addresses.
- R7: At request acceptance, three errors are checked. Status bit 2 is set if the source address is not a multiple of the source width. Status bit 3 is set if the destination address is not a multiple of the destination width. Status bit 4 is set if NBYTES is zero or not a multiple of the larger width. On any error no data moves, the count is unchanged, `err_o` pulses for one cycle, and `err_flags_o` = {bit4, bit3, bit2}. While any error bit is set, all requests are ignored.
- R8: Writing register 9 clears each status bit (0 done, 1 irq, 2 to 4 errors) whose data bit is 1 and leaves the others unchanged.
- R9: A request arriving while an inner loop is in progress is held and served once that loop ends, without a further request.
- R10: With a one-cycle memory acknowledge, `busy_o` falls and completion status appears exactly (reads + writes + 1) clock cycles after the edge that samples the request.
- R11: Beat widths are log2-encoded in register 3 (bits [1:0] source, [5:4] destination; 0 = 1 byte to 3 = 8 bytes). Read data is right-justified, and bytes are packed little-endian in staging, so byte order is kept across width changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| periph_req | input | 1 | One-cycle transfer request from the peripheral |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_size | output | 2 | Beat width, log2 bytes |
| mem_wdata | output | 64 | Write data, right-justified |
| mem_rdata | input | 64 | Read data, right-justified |
| mem_ack | input | 1 | Beat complete |
| busy_o | output | 1 | Inner loop in progress |
| cur_iter_o | output | CNT_W | Current iteration count |
| done_o | output | 1 | Outer loop complete (status bit 0) |
| irq_o | output | 1 | Interrupt flag (status bit 1) |
| err_flags_o | output | 3 | {count error, destination alignment, source alignment} |
| err_o | output | 1 | One-cycle error pulse |

## Verification
Results are due at fixed distances from the edge that samples a request. Error flags and the `err_o` pulse appear straight after that edge, and `err_o` is gone one cycle later. `busy_o`, the count, completion and interrupt status settle (reads + writes + 1) cycles after it. The bench counts falling edges from that sampling edge. It checks the cycle just before and just after the due edge, and it compares memory contents only once the channel has stayed idle for two cycles. Requests that must be ignored are followed by idle cycles and then checked at the count, the busy output and the destination memory.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

   typedef enum logic [3:0] {
      RG_SRC    = 4'd0,
      RG_DST    = 4'd1,
      RG_OFS    = 4'd2,
      RG_SIZE   = 4'd3,
      RG_NBYTES = 4'd4,
      RG_SADJ   = 4'd5,
      RG_DADJ   = 4'd6,
      RG_ITER   = 4'd7,
      RG_CTRL   = 4'd8,
      RG_STAT   = 4'd9
   } reg_idx_e;

   typedef enum logic [1:0] {
      MV_IDLE,
      MV_READ,
      MV_WRITE,
      MV_FINISH
   } mv_state_e;

   typedef struct packed {
      logic cnt_bad;
      logic dst_misal;
      logic src_misal;
   } cfg_err_t;

   function automatic logic [3:0] size_bytes(input logic [1:0] lg);
      return 4'd1 << lg;
   endfunction

endpackage

// File: rtl/dmaeng_regs.sv
module dmaeng_regs
   import dmaeng_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 12,
   parameter int NB_W     = 16,
   parameter bit HALF_IRQ = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [3:0]               cfg_addr,
   input  logic [31:0]              cfg_wdata,
   input  logic                     major_ev,
   input  logic                     half_ev,
   input  cfg_err_t                 err_ev,
   output logic signed [15:0]       soff,
   output logic signed [15:0]       doff,
   output logic [1:0]               ssize_l,
   output logic [1:0]               dsize_l,
   output logic [NB_W-1:0]          nbytes,
   output logic [ADDR_W-1:0]        sadj,
   output logic [ADDR_W-1:0]        dadj,
   output logic [CNT_W-1:0]         biter,
   output logic                     req_en,
   output logic                     src_ld,
   output logic                     dst_ld,
   output logic                     iter_ld,
   output logic                     done,
   output logic                     irq,
   output cfg_err_t                 errs,
   output logic                     err_pulse
)/* register file */;

   logic       imaj_q, ihalf_q, half_hit;
   logic [4:0] clr;
   logic       unused_wdata;

   assign unused_wdata = ^cfg_wdata;

   assign src_ld  = cfg_we && (cfg_addr == 4'(RG_SRC));
   assign dst_ld  = cfg_we && (cfg_addr == 4'(RG_DST));
   assign iter_ld = cfg_we && (cfg_addr == 4'(RG_ITER));
   assign clr     = (cfg_we && (cfg_addr == 4'(RG_STAT))) ? cfg_wdata[4:0] : 5'd0;

   generate
      if (HALF_IRQ) begin : g_half
         assign half_hit = half_ev & ihalf_q;
      end else begin : g_nohalf
         logic unused_half;
         assign unused_half = half_ev ^ ihalf_q;
         assign half_hit    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         soff    <= '0;
         doff    <= '0;
         ssize_l <= '0;
         dsize_l <= '0;
         nbytes  <= '0;
         sadj    <= '0;
         dadj    <= '0;
         biter   <= '0;
         req_en  <= 1'b0;
         imaj_q  <= 1'b0;
         ihalf_q <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_addr)
            4'(RG_OFS): begin
               soff <= cfg_wdata[15:0];
               doff <= cfg_wdata[31:16];
            end
            4'(RG_SIZE): begin
               ssize_l <= cfg_wdata[1:0];
               dsize_l <= cfg_wdata[5:4];
            end
            4'(RG_NBYTES): nbytes <= cfg_wdata[NB_W-1:0];
            4'(RG_SADJ):   sadj   <= cfg_wdata[ADDR_W-1:0];
            4'(RG_DADJ):   dadj   <= cfg_wdata[ADDR_W-1:0];
            4'(RG_ITER):   biter  <= cfg_wdata[CNT_W-1:0];
            4'(RG_CTRL): begin
               req_en  <= cfg_wdata[0];
               imaj_q  <= cfg_wdata[1];
               ihalf_q <= cfg_wdata[2];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         irq       <= 1'b0;
         errs      <= '0;
         err_pulse <= 1'b0;
      end else begin
         done           <= (done & ~clr[0]) | major_ev;
         irq            <= (irq & ~clr[1]) | (major_ev & imaj_q) | half_hit;
         errs.src_misal <= (errs.src_misal & ~clr[2]) | err_ev.src_misal;
         errs.dst_misal <= (errs.dst_misal & ~clr[3]) | err_ev.dst_misal;
         errs.cnt_bad   <= (errs.cnt_bad   & ~clr[4]) | err_ev.cnt_bad;
         err_pulse      <= |err_ev;
      end
   end

   AST_DONE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      major_ev |=> done) else $error("done not set"); // R3

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_ev) |=> (err_pulse && (errs != '0))) else $error("error not flagged"); // R7

endmodule

// File: rtl/dmaeng_check.sv
module dmaeng_check
   import dmaeng_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NB_W   = 16
) (
   input  logic [ADDR_W-1:0] saddr,
   input  logic [ADDR_W-1:0] daddr,
   input  logic [1:0]        ssize_l,
   input  logic [1:0]        dsize_l,
   input  logic [NB_W-1:0]   nbytes,
   output cfg_err_t          chk
);

   logic [2:0] smask, dmask, wmask;
   logic [1:0] wide_l;
   logic       unused_hi;

   assign unused_hi = ^{saddr[ADDR_W-1:3], daddr[ADDR_W-1:3]};
   assign wide_l    = (ssize_l > dsize_l) ? ssize_l : dsize_l;
   assign smask     = 3'(size_bytes(ssize_l) - 4'd1);
   assign dmask     = 3'(size_bytes(dsize_l) - 4'd1);
   assign wmask     = 3'(size_bytes(wide_l) - 4'd1);

   assign chk.src_misal = |(saddr[2:0] & smask);
   assign chk.dst_misal = |(daddr[2:0] & dmask);
   assign chk.cnt_bad   = (nbytes == '0) || (|(nbytes[2:0] & wmask));

endmodule

// File: rtl/dmaeng_mover.sv
module dmaeng_mover
   import dmaeng_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 12,
   parameter int NB_W   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 periph_req,
   input  logic                 req_en,
   input  logic                 err_block,
   input  cfg_err_t             chk,
   input  logic signed [15:0]   soff,
   input  logic signed [15:0]   doff,
   input  logic [1:0]           ssize_l,
   input  logic [1:0]           dsize_l,
   input  logic [NB_W-1:0]      nbytes,
   input  logic [ADDR_W-1:0]    sadj,
   input  logic [ADDR_W-1:0]    dadj,
   input  logic [CNT_W-1:0]     biter,
   input  logic                 src_ld,
   input  logic                 dst_ld,
   input  logic                 iter_ld,
   input  logic [31:0]          ld_data,
   output logic [ADDR_W-1:0]    saddr,
   output logic [ADDR_W-1:0]    daddr,
   output logic [CNT_W-1:0]     citer,
   output logic                 busy,
   output logic                 major_ev,
   output logic                 half_ev,
   output cfg_err_t             err_ev,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [1:0]           mem_size,
   output logic [63:0]          mem_wdata,
   input  logic [63:0]          mem_rdata,
   input  logic                 mem_ack
);

   mv_state_e   state_q;
   logic        pend_q, take, start, last_iter;
   logic [3:0]  fill_q, drain_q, ssz, dsz, chunk, fill_nxt, drain_nxt;
   logic [1:0]  wide_l;
   logic [NB_W-1:0] left_q;
   logic [63:0] stage_q, rmask;
   logic [ADDR_W-1:0] soff_x, doff_x;
   logic [CNT_W-1:0]  citer_dec;
   logic        unused_ld;

   assign unused_ld = ^ld_data;
   assign wide_l    = (ssize_l > dsize_l) ? ssize_l : dsize_l;
   assign ssz       = size_bytes(ssize_l);
   assign dsz       = size_bytes(dsize_l);
   assign chunk     = size_bytes(wide_l);
   assign fill_nxt  = fill_q + ssz;
   assign drain_nxt = drain_q + dsz;
   assign soff_x    = {{(ADDR_W-16){soff[15]}}, soff};
   assign doff_x    = {{(ADDR_W-16){doff[15]}}, doff};
   assign rmask     = ~(64'hFFFF_FFFF_FFFF_FFFF << {ssz, 3'b000});
   assign citer_dec = citer - CNT_W'(1);
   assign last_iter = (citer <= CNT_W'(1));

   // a request is taken in idle only; it either starts a loop or reports errors
   assign take  = (state_q == MV_IDLE) && (periph_req || pend_q) && req_en && !err_block;
   assign start = take && (chk == '0);
   assign err_ev = take ? chk : '0;

   assign busy      = (state_q != MV_IDLE);
   assign mem_req   = (state_q == MV_READ) || (state_q == MV_WRITE);
   assign mem_we    = (state_q == MV_WRITE);
   assign mem_addr  = mem_we ? daddr : saddr;
   assign mem_size  = mem_we ? dsize_l : ssize_l;
   assign mem_wdata = stage_q >> {drain_q, 3'b000};
   assign major_ev  = (state_q == MV_FINISH) && last_iter;
   assign half_ev   = (state_q == MV_FINISH) && (citer_dec == (biter >> 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= (pend_q && !take) ||
                   (periph_req && req_en && !err_block && !(take && !pend_q));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MV_IDLE;
         saddr   <= '0;
         daddr   <= '0;
         citer   <= '0;
         fill_q  <= '0;
         drain_q <= '0;
         left_q  <= '0;
         stage_q <= '0;
      end else begin
         case (state_q)
            MV_IDLE: begin
               if (start) begin
                  state_q <= MV_READ;
                  left_q  <= nbytes;
                  fill_q  <= '0;
                  stage_q <= '0;
               end
            end
            MV_READ: begin
               if (mem_ack) begin
                  stage_q <= stage_q | ((mem_rdata & rmask) << {fill_q, 3'b000});
                  saddr   <= saddr + soff_x;
                  if (fill_nxt == chunk) begin
                     state_q <= MV_WRITE;
                     drain_q <= '0;
                  end else begin
                     fill_q <= fill_nxt;
                  end
               end
            end
            MV_WRITE: begin
               if (mem_ack) begin
                  daddr   <= daddr + doff_x;
                  drain_q <= drain_nxt;
                  if (drain_nxt == chunk) begin
                     if (left_q == NB_W'(chunk)) begin
                        state_q <= MV_FINISH;
                     end else begin
                        state_q <= MV_READ;
                        left_q  <= left_q - NB_W'(chunk);
                        fill_q  <= '0;
                        stage_q <= '0;
                     end
                  end
               end
            end
            default: begin
               state_q <= MV_IDLE;
               if (last_iter) begin
                  citer <= biter;
                  saddr <= saddr + sadj;
                  daddr <= daddr + dadj;
               end else begin
                  citer <= citer_dec;
               end
            end
         endcase
         if (src_ld)  saddr <= ld_data[ADDR_W-1:0];
         if (dst_ld)  daddr <= ld_data[ADDR_W-1:0];
         if (iter_ld) citer <= ld_data[CNT_W-1:0];
      end
   end

   AST_ERQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_IDLE && !req_en && !pend_q) |=> (state_q == MV_IDLE))
      else $error("start without enable"); // R6

   AST_ERR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_IDLE && err_block) |=> (state_q == MV_IDLE))
      else $error("start while errored"); // R7

   AST_ITER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_FINISH && !last_iter && !iter_ld) |=> (citer == $past(citer) - CNT_W'(1)))
      else $error("count step wrong"); // R2

   AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      citer <= biter) else $error("count above start"); // R2

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_READ) |-> (fill_q < chunk)) else $error("staging overrun"); // R11

endmodule

// File: rtl/dmaeng_channel.sv
module dmaeng_channel
   import dmaeng_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 12,
   parameter int NB_W     = 16,
   parameter bit HALF_IRQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              periph_req,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [63:0]       mem_wdata,
   input  logic [63:0]       mem_rdata,
   input  logic              mem_ack,
   output logic              busy_o,
   output logic [CNT_W-1:0]  cur_iter_o,
   output logic              done_o,
   output logic              irq_o,
   output logic [2:0]        err_flags_o,
   output logic              err_o
);

   initial begin
      assert (ADDR_W >= 17 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (CNT_W >= 2 && CNT_W <= 16) else $error("CNT_W out of range");
      assert (NB_W >= 4 && NB_W <= 32) else $error("NB_W out of range");
   end

   logic signed [15:0] soff, doff;
   logic [1:0]         ssize_l, dsize_l;
   logic [NB_W-1:0]    nbytes;
   logic [ADDR_W-1:0]  sadj, dadj, saddr, daddr;
   logic [CNT_W-1:0]   biter;
   logic               req_en, src_ld, dst_ld, iter_ld, major_ev, half_ev;
   cfg_err_t           err_ev, errs, chk;

   dmaeng_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NB_W(NB_W), .HALF_IRQ(HALF_IRQ)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .major_ev(major_ev), .half_ev(half_ev), .err_ev(err_ev),
      .soff(soff), .doff(doff), .ssize_l(ssize_l), .dsize_l(dsize_l), .nbytes(nbytes),
      .sadj(sadj), .dadj(dadj), .biter(biter), .req_en(req_en),
      .src_ld(src_ld), .dst_ld(dst_ld), .iter_ld(iter_ld),
      .done(done_o), .irq(irq_o), .errs(errs), .err_pulse(err_o)
   );

   dmaeng_check #(.ADDR_W(ADDR_W), .NB_W(NB_W)) u_check (
      .saddr(saddr), .daddr(daddr), .ssize_l(ssize_l), .dsize_l(dsize_l),
      .nbytes(nbytes), .chk(chk)
   );

   dmaeng_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_mover (
      .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .req_en(req_en),
      .err_block(errs != '0), .chk(chk), .soff(soff), .doff(doff),
      .ssize_l(ssize_l), .dsize_l(dsize_l), .nbytes(nbytes), .sadj(sadj), .dadj(dadj),
      .biter(biter), .src_ld(src_ld), .dst_ld(dst_ld), .iter_ld(iter_ld), .ld_data(cfg_wdata),
      .saddr(saddr), .daddr(daddr), .citer(cur_iter_o), .busy(busy_o),
      .major_ev(major_ev), .half_ev(half_ev), .err_ev(err_ev),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   assign err_flags_o = {errs.cnt_bad, errs.dst_misal, errs.src_misal};

endmodule

// File: tb/test_dmaeng_channel.sv
module test_dmaeng_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        periph_req = 1'b0;
   logic        mem_req, mem_we, busy_o, done_o, irq_o, err_o;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic [63:0] mem_wdata, mem_rdata;
   logic [11:0] cur_iter_o;
   logic [2:0]  err_flags_o;
   logic [7:0]  mem [256];
   int          n_tests = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   dmaeng_channel i_dmaeng_channel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .periph_req(periph_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_req),
      .busy_o(busy_o), .cur_iter_o(cur_iter_o), .done_o(done_o), .irq_o(irq_o),
      .err_flags_o(err_flags_o), .err_o(err_o)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 7 + 3);
   endfunction

   always_comb begin
      mem_rdata = '0;
      for (int k = 0; k < 8; k++)
         if (k < (1 << mem_size)) mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + 8'(k))];
   end

   always @(posedge clk)
      if (mem_req && mem_we)
         for (int k = 0; k < 8; k++)
            if (k < (1 << mem_size)) mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_req(input int len);
      @(negedge clk);
      periph_req = 1'b1;
      repeat (len) @(negedge clk);
      periph_req = 1'b0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      for (int n = 0; n < 500 && quiet < 2; n++) begin
         @(negedge clk);
         quiet = busy_o ? 0 : quiet + 1;
      end
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] ofs,
                        input logic [31:0] sz, input logic [31:0] nb, input logic [31:0] sa,
                        input logic [31:0] da, input logic [31:0] it, input logic [31:0] ctl);
      wr(4'd0, s); wr(4'd1, d); wr(4'd2, ofs); wr(4'd3, sz); wr(4'd4, nb);
      wr(4'd5, sa); wr(4'd6, da); wr(4'd7, it); wr(4'd8, ctl); wr(4'd9, 32'h1F);
   endtask

   task automatic t_reset();
      chk("R1 done", done_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 flags", err_flags_o, 0);
      chk("R1 err", err_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 memreq", mem_req, 0);
      chk("R1 count", cur_iter_o, 0);
   endtask

   task automatic t_basic();
      setup(32'h10, 32'h80, 32'h0004_0004, 32'h22, 8, 32'hFFFF_FFE8, 8, 3, 32'h3);
      chk("R2 count load", cur_iter_o, 3);
      for (int i = 0; i < 3; i++) begin
         pulse_req(1);
         if (i == 0)
            for (int k = 1; k <= 5; k++) begin
               @(negedge clk);
               if (k == 4) chk("R10 busy before due", busy_o, 1);
               if (k == 5) chk("R10 busy falls", busy_o, 0);
            end
         wait_idle();
         chk("R2 count step", cur_iter_o, (i == 2) ? 3 : 2 - i);
         if (i == 1) chk("R3 no early done", done_o, 0);
      end
      chk("R3 done", done_o, 1);
      chk("R3 irq major", irq_o, 1);
      chk("R2 first byte", mem[8'h80], pat(8'h10));
      chk("R2 last byte", mem[8'h97], pat(8'h27));
      chk("R2 no extra byte", mem[8'h98], pat(8'h98));
      pulse_req(1);
      wait_idle();
      chk("R5 src adjust", mem[8'hA0], pat(8'h10));
      chk("R5 dst adjust", mem[8'hA7], pat(8'h17));
   endtask

   task automatic t_width();
      setup(32'h21, 32'hC0, 32'h0004_0001, 32'h20, 8, 0, 0, 1, 32'h3);
      pulse_req(1);
      for (int k = 1; k <= 11; k++) begin
         @(negedge clk);
         if (k == 10) chk("R10 done not yet", done_o, 0);
         if (k == 11) chk("R10 done due", done_o, 1);
      end
      for (int j = 0; j < 8; j++) chk("R11 narrow to wide", mem[8'(8'hC0 + j)], pat(8'h21 + j));
      setup(32'h28, 32'hD0, 32'h0001_0008, 32'h03, 8, 0, 0, 1, 32'h3);
      pulse_req(1);
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         if (k == 9) chk("R10 wide done not yet", done_o, 0);
         if (k == 10) chk("R10 wide done due", done_o, 1);
      end
      for (int j = 0; j < 8; j += 3) chk("R11 wide to narrow", mem[8'(8'hD0 + j)], pat(8'h28 + j));
   endtask

   task automatic t_half();
      setup(32'h10, 32'h80, 32'h0004_0004, 32'h22, 4, 0, 0, 4, 32'h5);
      pulse_req(1); wait_idle();
      chk("R4 no irq at 3", irq_o, 0);
      pulse_req(1); wait_idle();
      chk("R4 irq at half", irq_o, 1);
      wr(4'd9, 32'h2);
      chk("R8 irq cleared", irq_o, 0);
      chk("R8 done kept", done_o, 0);
      pulse_req(1); wait_idle();
      pulse_req(1); wait_idle();
      chk("R3 done no irq", {done_o, irq_o}, 2'b10);
      chk("R3 reload", cur_iter_o, 4);
   endtask

   task automatic t_erq_pend();
      setup(32'h10, 32'hE0, 32'h0004_0004, 32'h22, 4, 0, 0, 8, 32'h0);
      pulse_req(1);
      repeat (6) @(negedge clk);
      chk("R6 dropped count", cur_iter_o, 8);
      chk("R6 dropped busy", busy_o, 0);
      chk("R6 dropped mem", mem[8'hE0], pat(8'hE0));
      wr(4'd8, 1);
      pulse_req(1); wait_idle();
      chk("R6 enabled count", cur_iter_o, 7);
      wr(4'd8, 0); wr(4'd8, 1);
      pulse_req(1); wait_idle();
      chk("R6 resume count", cur_iter_o, 6);
      chk("R6 resume address", mem[8'hE4], pat(8'h14));
      pulse_req(2); wait_idle();
      chk("R9 pending served", cur_iter_o, 4);
      chk("R9 pending data", mem[8'hEC], pat(8'h1C));
   endtask

   task automatic t_errors();
      setup(32'h12, 32'hF0, 32'h0004_0004, 32'h22, 4, 0, 0, 2, 32'h1);
      pulse_req(1);
      chk("R7 src flag", err_flags_o, 3'b001);
      chk("R7 pulse high", err_o, 1);
      @(negedge clk);
      chk("R7 pulse low", err_o, 0);
      chk("R7 count kept", cur_iter_o, 2);
      chk("R7 no data", mem[8'hF0], pat(8'hF0));
      wr(4'd0, 32'h10);
      pulse_req(1);
      repeat (6) @(negedge clk);
      chk("R7 blocked", cur_iter_o, 2);
      wr(4'd9, 32'h04);
      chk("R8 flags cleared", err_flags_o, 0);
      pulse_req(1); wait_idle();
      chk("R7 runs after clear", cur_iter_o, 1);
      chk("R7 data after clear", mem[8'hF0], pat(8'h10));
      wr(4'd1, 32'hF5);
      pulse_req(1);
      chk("R7 dst flag", err_flags_o, 3'b010);
      wr(4'd9, 32'h08); wr(4'd1, 32'hF4); wr(4'd4, 6);
      pulse_req(1);
      chk("R7 count flag", err_flags_o, 3'b100);
      wr(4'd9, 32'h10); wr(4'd4, 0);
      pulse_req(1);
      chk("R7 zero count flag", err_flags_o, 3'b100);
      chk("R7 count unchanged", cur_iter_o, 1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = pat(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_width();
      t_half();
      t_erq_pend();
      t_errors();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule